// File: doc/BRIEF.md
# Video VSYNC Genlock Controller

This block locks the vertical sync of a display timing generator to the vertical sync of an incoming video stream. Both VSYNC inputs pass through a two-flop synchronizer. A one-cycle pulse then marks the edge that a control bit selects for each input. When the selected edge of the input VSYNC arrives and a lock mode is active, a 21-bit counter runs off the programmed delay in clock cycles. The clock is nominally 27 MHz. When the count finishes, the block issues a one-cycle align pulse, which resets the display timing generator.

Two lock modes exist. A single-shot request produces exactly one align pulse and then clears itself. Continuous mode re-aligns the display on every selected input edge. The block also has a field watchdog. Each selected input edge loads the timeout of the current field, odd or even, and the counter then counts down on line-rate ticks. If it runs out before the next input edge, the block sets a sticky flag for that field, which software clears by writing 1. A small word-wide register port holds the control, delay and timeout settings.

Top module: `vsync_genlock`

## Requirements
- R1: After reset, CTRL (address 0) reads 0, DELAY (address 1) reads 0, TMO (address 2) reads 0x1FFF1FFF, and `align_pulse` and `disp_edge` are 0.
- R2: CTRL bit 2 selects the input VSYNC edge (0 rising, 1 falling). Only the selected edge starts a lock. If `in_vsync` takes its new level at clock edge k and DELAY holds D, `align_pulse` is high for exactly the one cycle after clock edge k+3+D.
- R3: DELAY bits [20:0] hold the lock delay, and bits above 20 read as 0. With D = 0, the align pulse follows clock edge k+3.
- R4: With CTRL bit 1 (continuous) set, every selected input edge produces one align pulse.
- R5: Writing CTRL bit 0 (single-shot) arms exactly one lock. The next selected input edge starts it and clears bit 0 in hardware. While that single-shot count runs, further input edges do not restart it, even with bit 1 set.
- R6: In continuous mode, a selected input edge that arrives while a count is running restarts the count from DELAY. Only the restarted count produces an align pulse.
- R7: CTRL bit 3 selects the display VSYNC edge (0 rising, 1 falling). `disp_edge` pulses for the one cycle after clock edge k+1 when `disp_vsync` takes its new level at edge k on the selected edge, and it stays low on the other edge.
- R8: TMO bits [15:0] hold the odd-field timeout N and bits [31:16] the even-field timeout. Each selected input edge loads the value for the field that `field_odd` shows at that edge (1 = odd). With CTRL bit 4 set, the Nth `line_tick` after the load sets CTRL bit 8 (odd) or bit 9 (even). A new input edge before the Nth tick reloads the counter, and no flag is set.
- R9: With CTRL bit 4 clear, line ticks set neither timeout flag.
- R10: Flags in CTRL bits 8 and 9 stay set until a CTRL write carries 1 in that bit position. Writing 0 there leaves the flag unchanged.
- R11: Address 3 reads 0. TMO reads back exactly what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock (27 MHz nominal) |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vsync | input | 1 | Incoming video VSYNC, asynchronous |
| disp_vsync | input | 1 | Display timing generator VSYNC, asynchronous |
| field_odd | input | 1 | Current field of the incoming video, 1 = odd |
| line_tick | input | 1 | One-cycle pulse at line rate, clocks the watchdog |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| align_pulse | output | 1 | One-cycle reset/align pulse to the display timing generator |
| disp_edge | output | 1 | One-cycle pulse on the selected display VSYNC edge |

## Verification
On every cycle, the assertions check the following. Edge pulses never last two cycles, and an align pulse lasts exactly one cycle. A restart in the same cycle suppresses the pending pulse. A running single-shot count is never disturbed by a new edge. The hardware clear of the single-shot bit takes effect. Timeout flags stay set until cleared, and the watchdog fires only once per load and only while enabled. Only the bench scenarios can show the end-to-end behaviour. That covers the exact latency from a VSYNC change to the align pulse for each edge selection and delay, and the choice between override and restart when a second edge lands during a count. It also covers which field's flag a timeout sets after exactly N ticks, and register readback.

// File: rtl/genlock_pkg.sv
package genlock_pkg;

  typedef enum logic [1:0] {
    A_CTRL  = 2'd0,
    A_DELAY = 2'd1,
    A_TMO   = 2'd2,
    A_NONE  = 2'd3
  } reg_addr_e;

  localparam int unsigned B_FLAG_ODD  = 8;
  localparam int unsigned B_FLAG_EVEN = 9;

  // Packed so that bit 0 is os, matching the CTRL register layout.
  typedef struct packed {
    logic tmo_en;
    logic disp_fall;
    logic in_fall;
    logic cont;
    logic os;
  } ctrl_t;

  // Selected-edge detection on a synchronized level.
  function automatic logic sel_edge(input logic prev, input logic cur, input logic fall);
    return fall ? (prev & ~cur) : (~prev & cur);
  endfunction

  // A watchdog count expires on the tick that takes it from 1 (or 0) to 0.
  function automatic logic tmo_last(input logic [31:0] value);
    return value <= 32'd1;
  endfunction

endpackage

// File: rtl/gl_sync_edge.sv
module gl_sync_edge
  import genlock_pkg::*;
#(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  input  logic fall_sel,
  output logic edge_pulse
);

  logic [STAGES:0] shreg;

  always_ff @(posedge clk) begin
    if (!rst_n) shreg <= '0;
    else        shreg <= {shreg[STAGES-1:0], async_in};
  end

  assign edge_pulse = sel_edge(shreg[STAGES], shreg[STAGES-1], fall_sel);

  AST_EDGE_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
    edge_pulse |=> (!edge_pulse || (fall_sel != $past(fall_sel)))); // R2

endmodule

// File: rtl/gl_regs.sv
module gl_regs
  import genlock_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned DELAY_W = 21,
  parameter int unsigned TMO_W   = 16,
  parameter logic [TMO_W-1:0] TMO_RST = 16'h1FFF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [1:0]         addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  input  logic               os_consume,
  input  logic               set_odd,
  input  logic               set_even,
  output ctrl_t              ctrl,
  output logic [DELAY_W-1:0] delay_val,
  output logic [TMO_W-1:0]   tmo_odd,
  output logic [TMO_W-1:0]   tmo_even
);

  localparam int unsigned CTRL_W = $bits(ctrl_t);

  logic ctrl_wr, delay_wr, tmo_wr;
  logic flag_odd, flag_even;
  logic clr_odd, clr_even;
  logic unused_wdata;

  assign ctrl_wr  = wr_en && (reg_addr_e'(addr) == A_CTRL);
  assign delay_wr = wr_en && (reg_addr_e'(addr) == A_DELAY);
  assign tmo_wr   = wr_en && (reg_addr_e'(addr) == A_TMO);
  assign clr_odd  = ctrl_wr && wdata[B_FLAG_ODD];
  assign clr_even = ctrl_wr && wdata[B_FLAG_EVEN];
  assign unused_wdata = ^wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl      <= '0;
      delay_val <= '0;
      tmo_odd   <= TMO_RST;
      tmo_even  <= TMO_RST;
      flag_odd  <= 1'b0;
      flag_even <= 1'b0;
    end else begin
      if (ctrl_wr)         ctrl    <= ctrl_t'(wdata[CTRL_W-1:0]);
      else if (os_consume) ctrl.os <= 1'b0;
      if (delay_wr) delay_val <= wdata[DELAY_W-1:0];
      if (tmo_wr) begin
        tmo_odd  <= wdata[TMO_W-1:0];
        tmo_even <= wdata[2*TMO_W-1:TMO_W];
      end
      flag_odd  <= set_odd  | (flag_odd  & ~clr_odd);
      flag_even <= set_even | (flag_even & ~clr_even);
    end
  end

  always_comb begin
    rdata = '0;
    case (reg_addr_e'(addr))
      A_CTRL: begin
        rdata[CTRL_W-1:0]  = ctrl;
        rdata[B_FLAG_ODD]  = flag_odd;
        rdata[B_FLAG_EVEN] = flag_even;
      end
      A_DELAY: rdata[DELAY_W-1:0] = delay_val;
      A_TMO: begin
        rdata[TMO_W-1:0]       = tmo_odd;
        rdata[2*TMO_W-1:TMO_W] = tmo_even;
      end
      default: rdata = '0;
    endcase
  end

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_odd && !clr_odd) |=> flag_odd); // R10
  AST_OS_SELFCLR: assert property (@(posedge clk) disable iff (!rst_n)
    (os_consume && !ctrl_wr) |=> !ctrl.os); // R5
  AST_SET_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (set_odd || set_even) |-> ctrl.tmo_en); // R9

endmodule

// File: rtl/gl_delay.sv
module gl_delay #(
  parameter int unsigned DELAY_W = 21
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_edge,
  input  logic               os_en,
  input  logic               cont_en,
  input  logic [DELAY_W-1:0] delay_val,
  output logic               align_pulse,
  output logic               os_consume
);

  logic [DELAY_W-1:0] cnt;
  logic busy, mode_os, accept, done;

  // A running single-shot count is never restarted.
  assign accept     = in_edge && (os_en || cont_en) && !(busy && mode_os);
  assign os_consume = accept && os_en;
  assign done       = busy && (cnt == '0) && !accept;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt         <= '0;
      busy        <= 1'b0;
      mode_os     <= 1'b0;
      align_pulse <= 1'b0;
    end else begin
      align_pulse <= done;
      if (accept) begin
        cnt     <= delay_val;
        busy    <= 1'b1;
        mode_os <= os_en;
      end else if (busy) begin
        if (cnt == '0) busy <= 1'b0;
        else           cnt  <= cnt - 1'b1;
      end
    end
  end

  AST_ALIGN_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    align_pulse |=> !align_pulse); // R4
  AST_RESTART_SUPPRESSES: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !align_pulse); // R6
  AST_OS_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mode_os && (cnt != '0)) |=> (cnt == ($past(cnt) - 1'b1))); // R5

endmodule

// File: rtl/gl_timeout.sv
module gl_timeout
  import genlock_pkg::*;
#(
  parameter int unsigned TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_edge,
  input  logic             field_odd,
  input  logic             tmo_en,
  input  logic             line_tick,
  input  logic [TMO_W-1:0] tmo_odd,
  input  logic [TMO_W-1:0] tmo_even,
  output logic             hit_odd,
  output logic             hit_even
);

  logic [TMO_W-1:0] cnt;
  logic run, cur_odd, step, fire;

  assign step     = run && tmo_en && line_tick && !in_edge;
  assign fire     = step && tmo_last(32'(cnt));
  assign hit_odd  = fire && cur_odd;
  assign hit_even = fire && !cur_odd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      run     <= 1'b0;
      cur_odd <= 1'b0;
    end else if (in_edge) begin
      cnt     <= field_odd ? tmo_odd : tmo_even;
      run     <= 1'b1;
      cur_odd <= field_odd;
    end else if (step) begin
      if (fire) begin
        cnt <= '0;
        run <= 1'b0;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  AST_FIRE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !(hit_odd || hit_even)); // R8
  AST_FIRE_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_odd || hit_even) |-> (line_tick && tmo_en)); // R9

endmodule

// File: rtl/vsync_genlock.sv
module vsync_genlock
  import genlock_pkg::*;
#(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned DELAY_W     = 21,
  parameter int unsigned TMO_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vsync,
  input  logic              disp_vsync,
  input  logic              field_odd,
  input  logic              line_tick,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              align_pulse,
  output logic              disp_edge
);

  localparam int unsigned N_SRC = 2;

  ctrl_t              ctrl;
  logic [DELAY_W-1:0] delay_val;
  logic [TMO_W-1:0]   tmo_odd, tmo_even;
  logic               os_consume, hit_odd, hit_even, in_edge;
  logic [N_SRC-1:0]   raw_vs, fall_sel, edges;

  assign raw_vs   = {disp_vsync, in_vsync};
  assign fall_sel = {ctrl.disp_fall, ctrl.in_fall};

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    gl_sync_edge #(.STAGES(SYNC_STAGES)) i_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .async_in  (raw_vs[g]),
      .fall_sel  (fall_sel[g]),
      .edge_pulse(edges[g])
    );
  end

  assign in_edge   = edges[0];
  assign disp_edge = edges[1];

  gl_regs #(
    .DATA_W (DATA_W),
    .DELAY_W(DELAY_W),
    .TMO_W  (TMO_W)
  ) i_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (reg_wr),
    .addr      (reg_addr),
    .wdata     (reg_wdata),
    .rdata     (reg_rdata),
    .os_consume(os_consume),
    .set_odd   (hit_odd),
    .set_even  (hit_even),
    .ctrl      (ctrl),
    .delay_val (delay_val),
    .tmo_odd   (tmo_odd),
    .tmo_even  (tmo_even)
  );

  gl_delay #(.DELAY_W(DELAY_W)) i_delay (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_edge    (in_edge),
    .os_en      (ctrl.os),
    .cont_en    (ctrl.cont),
    .delay_val  (delay_val),
    .align_pulse(align_pulse),
    .os_consume (os_consume)
  );

  gl_timeout #(.TMO_W(TMO_W)) i_tmo (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_edge  (in_edge),
    .field_odd(field_odd),
    .tmo_en   (ctrl.tmo_en),
    .line_tick(line_tick),
    .tmo_odd  (tmo_odd),
    .tmo_even (tmo_even),
    .hit_odd  (hit_odd),
    .hit_even (hit_even)
  );

endmodule

// File: tb/test_vsync_genlock.sv
`timescale 1ns/1ps
module test_vsync_genlock;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_vsync = 1'b0, disp_vsync = 1'b0, field_odd = 1'b0, line_tick = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        align_pulse, disp_edge;

  int tests = 0, fails = 0;
  int cyc, first_align, n_align, first_disp, n_disp;
  bit done = 1'b0;

  vsync_genlock i_vsync_genlock (
    .clk(clk), .rst_n(rst_n), .in_vsync(in_vsync), .disp_vsync(disp_vsync),
    .field_odd(field_odd), .line_tick(line_tick), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .align_pulse(align_pulse), .disp_edge(disp_edge)
  );

  always #5 clk = ~clk;

  task automatic check(input string req, input string what, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic meas_reset();
    cyc = 0; first_align = -1; n_align = 0; first_disp = -1; n_disp = 0;
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
      cyc++;
      if (align_pulse) begin if (first_align < 0) first_align = cyc; n_align++; end
      if (disp_edge)   begin if (first_disp  < 0) first_disp  = cyc; n_disp++;  end
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      line_tick = 1'b1; step(1); line_tick = 1'b0; step(1);
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(2'd0, d); check("R1", "CTRL reset", d, 32'h0);
    rd(2'd1, d); check("R1", "DELAY reset", d, 32'h0);
    rd(2'd2, d); check("R1", "TMO reset", d, 32'h1FFF1FFF);
    check("R1", "align reset", align_pulse, 0);
    check("R1", "disp_edge reset", disp_edge, 0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(2'd1, 32'hFFFF_FFFF); rd(2'd1, d); check("R3", "DELAY width", d, 32'h001F_FFFF);
    wr(2'd2, 32'h1234_ABCD); rd(2'd2, d); check("R11", "TMO readback", d, 32'h1234_ABCD);
    wr(2'd3, 32'hFFFF_FFFF); rd(2'd3, d); check("R11", "addr 3 reads 0", d, 32'h0);
    wr(2'd2, 32'h1FFF_1FFF);
  endtask

  task automatic t_cont_rise();
    wr(2'd1, 32'd5); wr(2'd0, 32'h2);
    meas_reset(); in_vsync = 1'b1; step(12);
    check("R2", "rise align cycle", first_align, 9);
    check("R2", "rise align count", n_align, 1);
    meas_reset(); in_vsync = 1'b0; step(12);
    check("R2", "falling edge ignored", n_align, 0);
    meas_reset(); in_vsync = 1'b1; step(12);
    check("R4", "second lock cycle", first_align, 9);
    check("R4", "second lock count", n_align, 1);
    in_vsync = 1'b0; step(4);
  endtask

  task automatic t_fall();
    wr(2'd0, 32'h6);
    meas_reset(); in_vsync = 1'b1; step(12);
    check("R2", "rise ignored in fall mode", n_align, 0);
    meas_reset(); in_vsync = 1'b0; step(12);
    check("R2", "fall align cycle", first_align, 9);
    check("R2", "fall align count", n_align, 1);
  endtask

  task automatic t_delay0();
    wr(2'd1, 32'd0); wr(2'd0, 32'h2);
    meas_reset(); in_vsync = 1'b1; step(8);
    check("R3", "zero delay cycle", first_align, 4);
    check("R3", "zero delay count", n_align, 1);
    in_vsync = 1'b0; step(4);
  endtask

  task automatic t_oneshot();
    logic [31:0] d;
    wr(2'd1, 32'd3); wr(2'd0, 32'h1);
    meas_reset(); in_vsync = 1'b1; step(12);
    check("R5", "one-shot cycle", first_align, 7);
    check("R5", "one-shot count", n_align, 1);
    rd(2'd0, d); check("R5", "one-shot bit self-clears", d[0], 0);
    in_vsync = 1'b0; step(4);
    meas_reset(); in_vsync = 1'b1; step(12);
    check("R5", "no pulse after one-shot", n_align, 0);
    in_vsync = 1'b0; step(4);
    // override: second edge lands during the count but must not restart it
    wr(2'd1, 32'd20); wr(2'd0, 32'h3);
    meas_reset(); in_vsync = 1'b1; step(3); in_vsync = 1'b0; step(3); in_vsync = 1'b1; step(40);
    check("R5", "override keeps first-edge timing", first_align, 24);
    check("R5", "override single pulse", n_align, 1);
    wr(2'd0, 32'h0); in_vsync = 1'b0; step(4);
  endtask

  task automatic t_restart();
    wr(2'd1, 32'd20); wr(2'd0, 32'h2);
    meas_reset(); in_vsync = 1'b1; step(3); in_vsync = 1'b0; step(3); in_vsync = 1'b1; step(40);
    check("R6", "restart timing", first_align, 30);
    check("R6", "restart single pulse", n_align, 1);
    wr(2'd0, 32'h0); in_vsync = 1'b0; step(4);
  endtask

  task automatic t_disp();
    meas_reset(); disp_vsync = 1'b1; step(5);
    check("R7", "disp rise cycle", first_disp, 2);
    check("R7", "disp rise count", n_disp, 1);
    meas_reset(); disp_vsync = 1'b0; step(5);
    check("R7", "disp fall ignored", n_disp, 0);
    wr(2'd0, 32'h8);
    meas_reset(); disp_vsync = 1'b1; step(5);
    check("R7", "disp rise ignored in fall mode", n_disp, 0);
    meas_reset(); disp_vsync = 1'b0; step(5);
    check("R7", "disp fall cycle", first_disp, 2);
    check("R7", "disp fall count", n_disp, 1);
    wr(2'd0, 32'h0);
  endtask

  task automatic t_timeout();
    logic [31:0] d;
    wr(2'd2, {16'd2, 16'd4}); wr(2'd0, 32'h10);
    field_odd = 1'b1; in_vsync = 1'b1; step(3);
    ticks(3); rd(2'd0, d); check("R8", "odd flag before N ticks", d[8], 0);
    ticks(1); rd(2'd0, d); check("R8", "odd flag at N ticks", d[8], 1);
    check("R8", "even flag untouched", d[9], 0);
    wr(2'd0, 32'h10); rd(2'd0, d); check("R10", "write 0 keeps flag", d[8], 1);
    wr(2'd0, 32'h110); rd(2'd0, d); check("R10", "write 1 clears flag", d[8], 0);
    in_vsync = 1'b0; step(2); field_odd = 1'b0; in_vsync = 1'b1; step(3);
    ticks(1); rd(2'd0, d); check("R8", "even flag before N ticks", d[9], 0);
    ticks(1); rd(2'd0, d); check("R8", "even flag at N ticks", d[9], 1);
    check("R8", "odd flag stays clear", d[8], 0);
    wr(2'd0, 32'h210); rd(2'd0, d); check("R10", "even flag clears", d[9], 0);
    field_odd = 1'b1; in_vsync = 1'b0; step(2); in_vsync = 1'b1; step(3);
    ticks(3); in_vsync = 1'b0; step(2); in_vsync = 1'b1; step(3); ticks(3);
    rd(2'd0, d); check("R8", "reload prevents timeout", d[8], 0);
    ticks(1); rd(2'd0, d); check("R8", "timeout after reload", d[8], 1);
    wr(2'd0, 32'h300);
    in_vsync = 1'b0; step(2); in_vsync = 1'b1; step(3); ticks(10);
    rd(2'd0, d); check("R9", "disabled: no flags", d[9:8], 0);
    in_vsync = 1'b0; step(2);
  endtask

  initial begin
    meas_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_regs();
    t_cont_rise();
    t_fall();
    t_delay0();
    t_oneshot();
    t_restart();
    t_disp();
    t_timeout();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule